// File: doc/BRIEF.md
# Software Trap Entry Sequencer

This block carries out the entry into a software trap for the two trap opcodes of a processor core that runs in either an emulation mode (8-bit stack page, three-byte frame) or a native mode (16-bit stack, four-byte frame). When the core decodes one of the two trap opcodes, it pulses `start` with the opcode, the mode bit, the program counter, the program bank, the status flags and the stack pointer. The sequencer then drives a byte-wide memory port for a fixed number of cycles. It skips the signature byte, pushes the return frame, and reads the 16-bit handler address from the vector slot that the opcode and the mode select.

When the sequence ends, a one-cycle `done` pulse presents the new program counter, the cleared program bank, the updated flags and the final stack pointer. The core loads these into its architectural registers. Reads are combinational: `mem_rdata` must be valid in the same cycle that `mem_re` and `mem_addr` are presented.

Top module: `trap_entry_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `mem_we` and `mem_re` are all low.
- R2: A `start` whose opcode is neither 0x00 nor 0x02 is ignored. `busy` stays low, and no read or write reaches the memory port.
- R3: The first memory access of a sequence reads the signature byte at address {bank, pc}. The program counter pushed afterwards is pc + 1, taken modulo 2^16.
- R4: In native mode the pushes are bank, PC high, PC low, flags, in that order. In emulation mode the pushes are PC high, PC low, flags. The flags byte pushed is the value given at `start`.
- R5: Each push writes to address {0x00, S} and then decrements S. `sp_out` holds the final S. In native mode S wraps across the full 16 bits.
- R6: In emulation mode the stack high byte is forced to 0x01 at start, and decrements wrap inside page 0x01.
- R7: The vector slot is selected as follows. Opcode 0x00 uses 0xFFE6 in native mode and 0xFFFE in emulation mode. Opcode 0x02 uses 0xFFE4 in native mode and 0xFFF4 in emulation mode. The slot is read from bank 0x00.
- R8: The low vector byte is read at the slot address, and the high byte at slot + 1 in the following cycle. `pc_out` is {high, low}.
- R9: At exit, `flags_out` equals the flags given at `start` with bit 2 (interrupt disable) set and bit 3 (decimal) cleared, and `bank_out` is 0x00.
- R10: `busy` is high for exactly 7 cycles in native mode and 6 in emulation mode. It is followed by a `done` pulse that lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a trap entry; sampled while idle |
| opcode | input | 8 | Trap opcode (0x00 or 0x02) |
| emu_mode | input | 1 | 1 = emulation mode, 0 = native mode |
| pc_in | input | 16 | Address of the signature byte |
| bank_in | input | 8 | Current program bank |
| flags_in | input | 8 | Current status flags |
| sp_in | input | 16 | Current stack pointer |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Handler address |
| bank_out | output | 8 | New program bank |
| flags_out | output | 8 | Updated flags |
| sp_out | output | 16 | Stack pointer after the pushes |

## Verification
The stack wrap cases are the hardest to reach from the ports. In emulation mode a push sequence must cross from 0x0100 to 0x01FF. In native mode it must cross from 0x0000 to 0xFFFF. The stimulus table starts the stack pointer right at those edges, and also starts the program counter at 0xFFFF, so that the pushed return address wraps to 0x0000. The memory model returns a byte derived from each address, so every vector slot produces a distinct handler address, and a wrong slot or a swapped byte order shows up in `pc_out`.

// File: rtl/trap_seq_pkg.sv
// Package: shared encodings for the trap entry sequencer.
// Assumes flag bit 2 is interrupt disable and flag bit 3 is decimal mode.
package trap_seq_pkg;
    localparam int PC_W   = 16;
    localparam int BANK_W = 8;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = PC_W + BANK_W;

    localparam logic [BYTE_W-1:0] OPC_BREAK  = 8'h00;
    localparam logic [BYTE_W-1:0] OPC_COPROC = 8'h02;

    localparam int FLAG_IRQ_OFF = 2;
    localparam int FLAG_DEC     = 3;

    localparam logic [BYTE_W-1:0] EMU_STACK_PAGE = 8'h01;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SIG,
        ST_PUSH_BANK,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_FLAGS,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/trap_vec_sel.sv
// Module: trap_vec_sel
// Decodes the trap opcode and the mode bit into a vector slot address.
// Assumes only the two trap opcodes are valid; any other opcode gives hit = 0.
module trap_vec_sel
    import trap_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    input  logic              emu_mode,
    output logic              hit,
    output logic [PC_W-1:0]   vec_addr
);
    // Select the slot from the opcode and the mode.
    always_comb begin
        hit      = 1'b0;
        vec_addr = '0;
        case (opcode)
            OPC_BREAK: begin
                hit      = 1'b1;
                vec_addr = emu_mode ? 16'hFFFE : 16'hFFE6;
            end
            OPC_COPROC: begin
                hit      = 1'b1;
                vec_addr = emu_mode ? 16'hFFF4 : 16'hFFE4;
            end
            default: begin
                hit      = 1'b0;
                vec_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/trap_stack_ptr.sv
// Module: trap_stack_ptr
// Holds the working stack pointer. It loads at start and steps down once per push.
// Assumes load and dec are never asserted together. In emulation mode the
// high byte is pinned to the stack page.
module trap_stack_ptr
    import trap_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] load_val,
    input  logic            emu_mode,
    input  logic            dec,
    output logic [PC_W-1:0] sp
);
    logic [PC_W-1:0] sp_q;
    logic [PC_W-1:0] sp_dec;
    logic [PC_W-1:0] sp_load;

    // Form the decremented value and the loaded value for the current mode.
    always_comb begin
        if (emu_mode) begin
            sp_dec  = {EMU_STACK_PAGE, sp_q[BYTE_W-1:0] - 8'd1};
            sp_load = {EMU_STACK_PAGE, load_val[BYTE_W-1:0]};
        end else begin
            sp_dec  = sp_q - 16'd1;
            sp_load = load_val;
        end
    end

    // Register the stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp_q <= '0;
        else if (load) sp_q <= sp_load;
        else if (dec)  sp_q <= sp_dec;
    end

    assign sp = sp_q;

    AST_EMU_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && emu_mode) |=> sp_q[PC_W-1:BYTE_W] == EMU_STACK_PAGE); // R6
endmodule

// File: rtl/trap_entry_seq.sv
// Module: trap_entry_seq (top)
// Sequences the entry into a software trap: it skips the signature byte,
// pushes the return frame, reads the handler vector, and reports the new state.
// Assumes memory reads are combinational and every access completes in one cycle.
module trap_entry_seq
    import trap_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] opcode,
    input  logic              emu_mode,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [BYTE_W-1:0] flags_in,
    input  logic [PC_W-1:0]   sp_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   pc_out,
    output logic [BANK_W-1:0] bank_out,
    output logic [BYTE_W-1:0] flags_out,
    output logic [PC_W-1:0]   sp_out
);
    seq_state_t        state_q, state_d;
    logic [PC_W-1:0]   pc_q;
    logic [BANK_W-1:0] bank_q;
    logic [BYTE_W-1:0] flags_q;
    logic [PC_W-1:0]   vec_q;
    logic [BYTE_W-1:0] vec_lo_q;
    logic              emu_q;
    logic              hit;
    logic [PC_W-1:0]   vec_sel;
    logic              accept;
    logic              sp_dec;
    logic [PC_W-1:0]   sp_cur;

    trap_vec_sel u_vec (
        .opcode   (opcode),
        .emu_mode (emu_mode),
        .hit      (hit),
        .vec_addr (vec_sel)
    );

    assign accept = (state_q == ST_IDLE) && start && hit;

    trap_stack_ptr u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (sp_in),
        .emu_mode (accept ? emu_mode : emu_q),
        .dec      (sp_dec),
        .sp       (sp_cur)
    );

    // Choose the next state; the bank push is skipped in emulation mode.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:       if (accept) state_d = ST_SIG;
            ST_SIG:        state_d = emu_q ? ST_PUSH_HI : ST_PUSH_BANK;
            ST_PUSH_BANK:  state_d = ST_PUSH_HI;
            ST_PUSH_HI:    state_d = ST_PUSH_LO;
            ST_PUSH_LO:    state_d = ST_PUSH_FLAGS;
            ST_PUSH_FLAGS: state_d = ST_VEC_LO;
            ST_VEC_LO:     state_d = ST_VEC_HI;
            ST_VEC_HI:     state_d = ST_DONE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Drive the memory port for the current step.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        sp_dec    = 1'b0;
        case (state_q)
            ST_SIG: begin
                mem_addr = {bank_q, pc_q};
                mem_re   = 1'b1;
            end
            ST_PUSH_BANK, ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_FLAGS: begin
                mem_addr = {8'h00, sp_cur};
                mem_we   = 1'b1;
                sp_dec   = 1'b1;
                case (state_q)
                    ST_PUSH_BANK: mem_wdata = bank_q;
                    ST_PUSH_HI:   mem_wdata = pc_q[PC_W-1:BYTE_W];
                    ST_PUSH_LO:   mem_wdata = pc_q[BYTE_W-1:0];
                    default:      mem_wdata = flags_q;
                endcase
            end
            ST_VEC_LO: begin
                mem_addr = {8'h00, vec_q};
                mem_re   = 1'b1;
            end
            ST_VEC_HI: begin
                mem_addr = {8'h00, vec_q + 16'd1};
                mem_re   = 1'b1;
            end
            default: ;
        endcase
    end

    // Advance the state and the working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pc_q     <= '0;
            bank_q   <= '0;
            flags_q  <= '0;
            vec_q    <= '0;
            vec_lo_q <= '0;
            emu_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE: if (accept) begin
                    pc_q    <= pc_in;
                    bank_q  <= bank_in;
                    flags_q <= flags_in;
                    vec_q   <= vec_sel;
                    emu_q   <= emu_mode;
                end
                ST_SIG:    pc_q     <= pc_q + 16'd1;
                ST_VEC_LO: vec_lo_q <= mem_rdata;
                ST_VEC_HI: begin
                    pc_q                  <= {mem_rdata, vec_lo_q};
                    bank_q                <= '0;
                    flags_q[FLAG_IRQ_OFF] <= 1'b1;
                    flags_q[FLAG_DEC]     <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done      = (state_q == ST_DONE);
    assign pc_out    = pc_q;
    assign bank_out  = bank_q;
    assign flags_out = flags_q;
    assign sp_out    = sp_cur;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re)); // R2
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R5
    AST_EMU_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && emu_q) |-> mem_addr[15:8] == EMU_STACK_PAGE); // R6
    AST_VEC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VEC_HI) |-> $past(state_q) == ST_VEC_LO); // R8
    AST_EXIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FLAG_IRQ_OFF] && !flags_out[FLAG_DEC] && bank_out == 8'h00)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

// File: tb/trap_entry_seq_tb.sv
// Bench for trap_entry_seq: walks a stimulus table, then runs directed tests.
module trap_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        emu_mode = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  bank_in = '0;
    logic [7:0]  flags_in = '0;
    logic [15:0] sp_in = '0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata;
    logic        busy;
    logic        done;
    logic [15:0] pc_out;
    logic [7:0]  bank_out;
    logic [7:0]  flags_out;
    logic [15:0] sp_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Memory model: each address returns a byte derived from the address.
    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction
    assign mem_rdata = mem_byte(mem_addr);

    trap_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .emu_mode(emu_mode), .pc_in(pc_in), .bank_in(bank_in),
        .flags_in(flags_in), .sp_in(sp_in), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_out(pc_out),
        .bank_out(bank_out), .flags_out(flags_out), .sp_out(sp_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Fields: opcode, emu, pc, bank, flags, sp.
    localparam logic [63:0] CASES [6] = '{
        {8'h00, 8'h01, 16'h1234, 8'h00, 8'h38, 16'h01F0},
        {8'h02, 8'h01, 16'hFFFF, 8'h00, 8'h30, 16'h0101},
        {8'h00, 8'h00, 16'h8000, 8'h7E, 8'h0B, 16'h1FFF},
        {8'h02, 8'h00, 16'h00FF, 8'hC3, 8'hFF, 16'h0000},
        {8'h00, 8'h01, 16'h4455, 8'h00, 8'h34, 16'h2280},
        {8'h02, 8'h00, 16'hABCD, 8'h00, 8'h00, 16'h0100}
    };

    logic [23:0] wa [8];
    logic [7:0]  wd [8];
    logic [23:0] ra [8];
    int nwr, nrd, nbusy;
    bit  hung = 0;

    task automatic run_case(input logic [7:0] op, input logic emu, input logic [15:0] pc,
                            input logic [7:0] bk, input logic [7:0] fl, input logic [15:0] sp);
        int guard;
        @(negedge clk);
        opcode = op; emu_mode = emu; pc_in = pc; bank_in = bk; flags_in = fl; sp_in = sp;
        start = 1'b1;
        nwr = 0; nrd = 0; nbusy = 0; guard = 0;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 40) begin
            if (busy) nbusy++;
            if (mem_we && nwr < 8) begin wa[nwr] = mem_addr; wd[nwr] = mem_wdata; nwr++; end
            if (mem_re && nrd < 8) begin ra[nrd] = mem_addr; nrd++; end
            guard++;
            @(negedge clk);
        end
        if (guard >= 40) hung = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_we && !mem_re, "R1 reset", {busy, done, mem_we, mem_re}, 0);
        rst_n = 1'b1;

        foreach (CASES[i]) begin
            logic [7:0]  op, bk, fl, vlo, vhi;
            logic        emu;
            logic [15:0] pc, sp, s, vec, pcr;
            logic [23:0] exp_a [4];
            logic [7:0]  exp_d [4];
            int nexp;
            op  = CASES[i][63:56]; emu = CASES[i][48]; pc = CASES[i][47:32];
            bk  = CASES[i][31:24]; fl  = CASES[i][23:16]; sp = CASES[i][15:0];
            run_case(op, emu, pc, bk, fl, sp);
            chk(!hung, "R10 completion", {31'd0, hung}, 0);
            pcr = pc + 16'd1;
            // Expected frame (R4, R5, R6).
            nexp = 0;
            if (!emu) begin exp_d[nexp] = bk; nexp++; end
            exp_d[nexp] = pcr[15:8]; nexp++;
            exp_d[nexp] = pcr[7:0];  nexp++;
            exp_d[nexp] = fl;        nexp++;
            s = emu ? {8'h01, sp[7:0]} : sp;
            for (int k = 0; k < nexp; k++) begin
                exp_a[k] = {8'h00, s};
                s = emu ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
            end
            chk(nwr == nexp, "R4 push count", nwr, nexp);
            for (int k = 0; k < nexp && k < nwr; k++) begin
                chk(wd[k] == exp_d[k], "R4 push data", wd[k], exp_d[k]);
                chk(wa[k] == exp_a[k], emu ? "R6 push address" : "R5 push address", wa[k], exp_a[k]);
            end
            chk(sp_out == s, "R5 final sp", sp_out, s);
            // R3: signature read first.
            chk(nrd == 3 && ra[0] == {bk, pc}, "R3 signature read", ra[0], {bk, pc});
            // R7, R8: vector slot and byte order.
            if (op == 8'h00) vec = emu ? 16'hFFFE : 16'hFFE6;
            else             vec = emu ? 16'hFFF4 : 16'hFFE4;
            chk(ra[1] == {8'h00, vec}, "R7 vector low address", ra[1], {8'h00, vec});
            chk(ra[2] == {8'h00, vec + 16'd1}, "R8 vector high address", ra[2], {8'h00, vec + 16'd1});
            vlo = mem_byte({8'h00, vec});
            vhi = mem_byte({8'h00, vec + 16'd1});
            chk(pc_out == {vhi, vlo}, "R8 handler pc", pc_out, {vhi, vlo});
            chk(flags_out == ((fl | 8'h04) & ~8'h08), "R9 flags", flags_out, (fl | 8'h04) & ~8'h08);
            chk(bank_out == 8'h00, "R9 bank", bank_out, 0);
            chk(nbusy == (emu ? 6 : 7), "R10 busy cycles", nbusy, emu ? 6 : 7);
            @(negedge clk);
            chk(!done && !busy, "R10 done pulse", {done, busy}, 0);
        end

        // R2: an unsupported opcode is ignored.
        begin
            bit seen;
            seen = 0;
            @(negedge clk);
            opcode = 8'hEA; emu_mode = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (8) begin
                if (busy || done || mem_we || mem_re) seen = 1;
                @(negedge clk);
            end
            chk(!seen, "R2 ignored opcode", {31'd0, seen}, 0);
        end

        // R1: a reset in the middle of a sequence returns the block to idle.
        run_case(8'h00, 1'b0, 16'h0010, 8'h01, 8'h00, 16'h0200);
        @(negedge clk);
        start = 1'b1; opcode = 8'h02;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re, "R1 mid-sequence reset", {busy, done, mem_we, mem_re}, 0);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule